// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single-word requests from a CPU-side requester into timed cycles on an external memory bus. It takes each request's address and finds one of eight chip-select areas from it. It then runs the cycle through two or three bus states and drives the address, the read strobe, the write strobe, the active-low chip selects and the write-data output enable. The requester holds its request until an acknowledge pulse arrives in the final state of the cycle. The requester may present the next request in that same cycle, so cycles can run back to back.

Between back-to-back cycles the block may place one idle state. This gives a slow device time to release the data bus before the next access starts. An idle state is placed only when all of these hold:

- the cycle that just finished was a read;
- the next access targets a different area;
- the matching policy bit is set.

There are two policy bits. One covers a read followed by a write, and the other covers a read followed by a read. When no idle state is placed, the read strobe of the first cycle rises on the same clock edge on which the next cycle's chip select falls.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst` is high and after it, with no request, all chip selects, `bus_rd_n` and `bus_wr_n` are high, and `bus_doe` and `ack` are low.
- R2: The area is `req_addr[15:13]`. During every bus state of a cycle, only `bus_cs_n[area]` is low and `bus_addr` equals the request address. Outside bus states, all chip selects are high.
- R3: A cycle lasts two states (T1, T2) when `three_state_mask[area]` is 0 and three states (T1, T2, T3) when it is 1. `ack` is high for exactly the final state.
- R4: In a read (`req_we`=0), `bus_rd_n` is low from T1 through the final state, and `bus_wr_n` stays high.
- R5: In a write (`req_we`=1), `bus_wr_n` is low and `bus_doe` is high from T2 through the final state. Both are inactive in T1. `bus_rd_n` stays high.
- R6: With `idle_rw_en`=1, a read followed directly by a write to a different area has exactly one idle state between them. In that idle state all chip selects are high and all strobes and `bus_doe` are inactive.
- R7: With `idle_rr_en`=1, a read followed directly by a read to a different area has exactly one idle state between them.
- R8: No idle state is placed when any of these holds:
  - the areas are equal;
  - the first cycle is a write;
  - the relevant enable bit is clear;
  - the bus was idle before the request.

  In those cases T1 follows the previous final state, or the idle bus, on the next clock.
- R9: `rdata` takes the value of `bus_din` sampled at the end of a read's final state, and it is valid from the cycle after `ack`.
- R10: While `bus_doe` is high, `bus_dout` equals the request's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| three_state_mask | input | 8 | Per-area cycle length, 1 = three states |
| idle_rw_en | input | 1 | Idle state for read then write to another area |
| idle_rr_en | input | 1 | Idle state for read then read to another area |
| ack | output | 1 | Final-state acknowledge pulse |
| rdata | output | 8 | Captured read data |
| bus_addr | output | 16 | External address |
| bus_cs_n | output | 8 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | 8 | Write data to the bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 8 | Read data from the bus |

## Verification
The bench runs back-to-back pairs of accesses over every combination of:

- first area and second area;
- read or write for each of the two accesses;
- both policy bits.

Odd-numbered areas are set to three states, so every pairing of two-state and three-state cycles also occurs. The count of idle states between the two cycles tells apart the four reasons for skipping the idle state: same area, write first, policy bit clear, and an idle bus. It also shows that each policy bit acts only on its own kind of following access. Strobe, output-enable and chip-select checks in every state separate the T1, T2 and T3 timing of reads and writes, and varied read data shows whether `rdata` is captured in the right state.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int AREA_W  = 3;
    localparam int N_AREAS = 1 << AREA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TI,
        ST_T1,
        ST_T2,
        ST_T3
    } bus_st_e;

    typedef struct packed {
        logic              is_read;
        logic              three;
        logic [AREA_W-1:0] area;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } access_t;

    function automatic logic [AREA_W-1:0] area_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: AREA_W];
    endfunction
endpackage

// File: rtl/ext_bus_cs_decode.sv
module ext_bus_cs_decode #(
    parameter int AREA_W  = 3,
    localparam int N_AREAS = 1 << AREA_W
) (
    input  logic               active,
    input  logic [AREA_W-1:0]  area,
    output logic [N_AREAS-1:0] cs_n
);
    for (genvar i = 0; i < N_AREAS; i++) begin : g_cs
        assign cs_n[i] = !(active && (area == AREA_W'(i)));
    end
endmodule

// File: rtl/ext_bus_idle_policy.sv
module ext_bus_idle_policy #(
    parameter int AREA_W = 3
) (
    input  logic              prev_valid,
    input  logic              prev_read,
    input  logic [AREA_W-1:0] prev_area,
    input  logic              next_read,
    input  logic [AREA_W-1:0] next_area,
    input  logic              rw_en,
    input  logic              rr_en,
    output logic              insert_idle
);
    logic area_change;
    logic policy_hit;

    always_comb begin
        area_change = prev_area != next_area;
        policy_hit  = next_read ? rr_en : rw_en;
        insert_idle = prev_valid && prev_read && area_change && policy_hit;
    end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ext_bus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               req_we,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [N_AREAS-1:0] three_state_mask,
    input  logic               idle_rw_en,
    input  logic               idle_rr_en,
    output logic               ack,
    output logic [DATA_W-1:0]  rdata,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [N_AREAS-1:0] bus_cs_n,
    output logic               bus_rd_n,
    output logic               bus_wr_n,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               bus_doe,
    input  logic [DATA_W-1:0]  bus_din
);
    bus_st_e           st, st_nxt;
    access_t           cur, incoming;
    logic              final_st, start, ins_idle, active, late;
    logic [AREA_W-1:0] req_area;

    assign req_area = area_of(req_addr);

    always_comb begin
        incoming.is_read = !req_we;
        incoming.three   = three_state_mask[req_area];
        incoming.area    = req_area;
        incoming.addr    = req_addr;
        incoming.wdata   = req_wdata;
    end

    ext_bus_idle_policy #(.AREA_W(AREA_W)) i_policy (
        .prev_valid (final_st),
        .prev_read  (cur.is_read),
        .prev_area  (cur.area),
        .next_read  (!req_we),
        .next_area  (req_area),
        .rw_en      (idle_rw_en),
        .rr_en      (idle_rr_en),
        .insert_idle(ins_idle)
    );

    always_comb begin
        final_st = (st == ST_T3) || (st == ST_T2 && !cur.three);
        start    = req && (st == ST_IDLE || final_st);
        active   = (st == ST_T1) || (st == ST_T2) || (st == ST_T3);
        late     = (st == ST_T2) || (st == ST_T3);
        st_nxt   = st;
        case (st)
            ST_IDLE: st_nxt = req ? ST_T1 : ST_IDLE;
            ST_TI:   st_nxt = ST_T1;
            ST_T1:   st_nxt = ST_T2;
            ST_T2:   st_nxt = cur.three ? ST_T3
                            : (req ? (ins_idle ? ST_TI : ST_T1) : ST_IDLE);
            ST_T3:   st_nxt = req ? (ins_idle ? ST_TI : ST_T1) : ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cur   <= '0;
            rdata <= '0;
        end else begin
            st <= st_nxt;
            if (final_st && cur.is_read) rdata <= bus_din;
            if (start) cur <= incoming;
        end
    end

    ext_bus_cs_decode #(.AREA_W(AREA_W)) i_decode (
        .active(active),
        .area  (cur.area),
        .cs_n  (bus_cs_n)
    );

    always_comb begin
        ack      = final_st;
        bus_addr = cur.addr;
        bus_dout = cur.wdata;
        bus_rd_n = !(active && cur.is_read);
        bus_wr_n = !(late && !cur.is_read);
        bus_doe  = late && !cur.is_read;
    end

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));
    // R2
    cs_area_chk: assert property (@(posedge clk) disable iff (rst)
        !(&bus_cs_n) |-> !bus_cs_n[area_of(bus_addr)]);
    // R4
    rd_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !(&bus_cs_n));
    // R5
    doe_excl_rd_chk: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> (bus_rd_n && !(&bus_cs_n)));
    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    // R6
    idle_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TI) |-> ($past(ack) && (&bus_cs_n) && !bus_doe && bus_rd_n));
    // R8
    idle_bus_direct_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && req) |=> (st == ST_T1));
endmodule

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
    import ext_bus_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst, req, req_we, idle_rw_en, idle_rr_en, ack;
    logic               bus_rd_n, bus_wr_n, bus_doe;
    logic [ADDR_W-1:0]  req_addr, bus_addr;
    logic [DATA_W-1:0]  req_wdata, rdata, bus_dout, bus_din;
    logic [N_AREAS-1:0] three_state_mask, bus_cs_n;

    ext_bus_seq i_ext_bus_seq (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .three_state_mask(three_state_mask),
        .idle_rw_en(idle_rw_en), .idle_rr_en(idle_rr_en), .ack(ack), .rdata(rdata),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    int checks = 0;
    int fails  = 0;
    logic             rd_pending = 1'b0;
    logic [DATA_W-1:0] rd_expect = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_rdata();
        if (rd_pending) begin
            check(rdata == rd_expect, "R9 rdata", 32'(rdata), 32'(rd_expect));
            rd_pending = 1'b0;
        end
    endtask

    // Called at a negedge; leaves the request held in the ack cycle.
    task automatic do_access(input bit we, input logic [2:0] area, input logic [12:0] low,
                             input logic [7:0] wd, input logic [7:0] din,
                             input int exp_gap, input string gap_tag);
        int gap = 0;
        int n;
        int len;
        logic [15:0] addr;
        addr = {area, low};
        len  = three_state_mask[area] ? 3 : 2;
        req = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        check_rdata();
        bus_din = din;
        while ((&bus_cs_n) && gap < 4) begin
            check(bus_rd_n && bus_wr_n && !bus_doe && !ack, "R6 idle strobes",
                  {bus_rd_n, bus_wr_n, bus_doe, ack}, 4'b1100);
            gap++;
            @(negedge clk);
        end
        check(gap == exp_gap, gap_tag, gap, exp_gap);
        for (n = 1; n <= 4; n++) begin
            check(bus_cs_n == ~(8'd1 << area), "R2 cs", 32'(bus_cs_n), 32'(~(8'd1 << area)));
            check(bus_addr == addr, "R2 addr", 32'(bus_addr), 32'(addr));
            check(bus_rd_n == we, "R4 rd_n", 32'(bus_rd_n), 32'(we));
            check(bus_wr_n == !(we && n >= 2), "R5 wr_n", 32'(bus_wr_n), 32'(!(we && n >= 2)));
            check(bus_doe == (we && n >= 2), "R5 doe", 32'(bus_doe), 32'(we && n >= 2));
            if (bus_doe) check(bus_dout == wd, "R10 dout", 32'(bus_dout), 32'(wd));
            check(ack == (n == len), "R3 ack", 32'(ack), 32'(n == len));
            if (ack) break;
            @(negedge clk);
        end
        check(n == len, "R3 length", n, len);
        if (!we) begin
            rd_pending = 1'b1;
            rd_expect  = din;
        end
    endtask

    task automatic go_idle();
        req = 1'b0;
        @(negedge clk);
        check_rdata();
        bus_din = 8'h5A;
        check((&bus_cs_n) && bus_rd_n && bus_wr_n && !bus_doe, "R8 idle bus",
              {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe}, 32'h7FE);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
        three_state_mask = 8'hAA; idle_rw_en = 1'b0; idle_rr_en = 1'b0; bus_din = '0;
        repeat (3) @(negedge clk);
        check((&bus_cs_n) && bus_rd_n && bus_wr_n && !bus_doe && !ack, "R1 in reset",
              {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, ack}, 32'hFFC);
        rst = 1'b0;
        @(negedge clk);
        check((&bus_cs_n) && bus_rd_n && bus_wr_n && !bus_doe && !ack, "R1 after reset",
              {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, ack}, 32'hFFC);
        for (int pol = 0; pol < 4; pol++) begin
            idle_rw_en = pol[0];
            idle_rr_en = pol[1];
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    for (int k = 0; k < 4; k++) begin
                        bit w1 = k[0];
                        bit w2 = k[1];
                        int eg;
                        string tg;
                        eg = (!w1 && a != b && (w2 ? pol[0] : pol[1])) ? 1 : 0;
                        tg = (eg == 1) ? (w2 ? "R6 gap" : "R7 gap") : "R8 gap";
                        do_access(w1, 3'(a), 13'(a * 613 + b * 97 + k * 5), 8'(a * 16 + b),
                                  8'(a * 29 + b * 7 + k), 0, "R8 gap from idle");
                        do_access(w2, 3'(b), 13'(b * 401 + a * 31 + k), 8'(b * 16 + a + k * 3),
                                  8'(b * 53 + a * 3 + k + 1), eg, tg);
                        go_idle();
                    end
                end
            end
        end
        summary();
        $finish;
    end
endmodule